// File: doc/BRIEF.md
# PCI Root Configuration Request Router

This block takes configuration requests that have already been decoded into bus, device, function and dword register index, and steers each one to the right target. A request to bus 0, device 0, function 0 is served by a small local register file that stands for the host bridge. Any other address goes to the downstream function slots. A presence table, loaded through its own sideband port, records which functions exist. Requests to absent functions never reach a slot.

Two registers of the host bridge can report the base address of the enhanced configuration window instead of their stored contents. Reads of the header-type dword from any non-root function gain the multifunction flag whenever a sibling function exists at the same bus and device. Read data comes back one cycle after the request, with a valid strobe.

Downstream slots see the request fields directly. The router adds a read strobe and a write strobe that are gated by presence and by bounds. For the read strobe, the slot returns its dword combinationally on `slot_rdata` in the same cycle.

Top module: `cfg_router`

## Requirements
- R1: A request whose bus, device and function are all zero never asserts `fwd_rd` or `fwd_wr`. A non-root read to a present function asserts `fwd_rd` in the request cycle, and the value of `slot_rdata` from that cycle is returned as read data.
- R2: While `ecam_en` is 1, a root read of register 24 returns `ecam_base[31:0]` with bit 0 forced to 1.
- R3: While `ecam_en` is 1, a root read of register 25 returns `ecam_base[63:32]`. While `ecam_en` is 0, both register 24 and register 25 read the stored values of the local register file.
- R4: A non-root read to an absent function returns 32'hFFFF_FFFF and does not assert `fwd_rd`.
- R5: A non-root read of register 3 (the header-type dword) sets bit 23 of the result when any of functions 1 to 7 is present at the same bus and device. A root read of register 3 never has bit 23 added.
- R6: A write where `req_offset + req_len > 4` changes no local register and does not assert `fwd_wr`.
- R7: A non-root write to an absent function does not assert `fwd_wr`. An in-bounds non-root write to a present function asserts `fwd_wr` in the request cycle.
- R8: In the local register file, a root write updates only the bytes `req_offset` to `req_offset+req_len-1`. Each byte is taken from its own lane of `req_wdata`. Register 0 is read-only and holds `ROOT_ID` (default 32'h4C21_1D0B). After reset, register 2 holds 32'h0600_0000 and all other registers hold 0. An index of `ROOT_DEPTH` (32) or more reads 0 and ignores writes.
- R9: `rd_valid` is 1 in exactly the cycle after each read request and 0 otherwise, including during reset.
- R10: When `pres_we` is 1, the presence bit of {`pres_bus`, `pres_dev`, `pres_fn`} is set to `pres_val`. Requests from the next cycle onward see the new value. All bits are clear after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | BUS_W | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_reg | input | REG_W | Dword register index |
| req_offset | input | 2 | Starting byte within the dword (writes) |
| req_len | input | 3 | Byte count 1 to 4 (writes) |
| req_wdata | input | 32 | Write data, each byte in its own lane |
| ecam_en | input | 1 | Enhanced window reporting enabled |
| ecam_base | input | 64 | Enhanced window base address |
| pres_we | input | 1 | Presence table write strobe |
| pres_bus | input | BUS_W | Presence entry bus |
| pres_dev | input | 5 | Presence entry device |
| pres_fn | input | 3 | Presence entry function |
| pres_val | input | 1 | Presence value to store |
| slot_rdata | input | 32 | Read data from the addressed slot |
| fwd_rd | output | 1 | Read forwarded to the addressed slot |
| fwd_wr | output | 1 | Write forwarded to the addressed slot |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |

## Verification
The assertions assume that every request lasts one cycle and that its fields are free of X while `req_valid` is high. They also assume that `slot_rdata` is meaningful only in a cycle where `fwd_rd` is asserted. The stimulus changes all inputs on the falling edge and holds `req_valid` for exactly one rising edge per request. It loads presence entries in cycles before the requests that depend on them. It keeps `slot_rdata` at a known pattern throughout each read.

// File: rtl/cfg_router.sv
module cfg_router #(
  parameter int          NUM_BUSES  = 4,
  parameter int          REG_W      = 8,
  parameter int          ROOT_DEPTH = 32,
  parameter logic [31:0] ROOT_ID    = 32'h4C21_1D0B,
  parameter logic [31:0] ROOT_CLASS = 32'h0600_0000,
  localparam int BUS_W = (NUM_BUSES > 1) ? $clog2(NUM_BUSES) : 1,
  localparam int RI_W  = $clog2(ROOT_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [BUS_W-1:0] req_bus,
  input  logic [4:0]       req_dev,
  input  logic [2:0]       req_fn,
  input  logic [REG_W-1:0] req_reg,
  input  logic [1:0]       req_offset,
  input  logic [2:0]       req_len,
  input  logic [31:0]      req_wdata,
  input  logic             ecam_en,
  input  logic [63:0]      ecam_base,
  input  logic             pres_we,
  input  logic [BUS_W-1:0] pres_bus,
  input  logic [4:0]       pres_dev,
  input  logic [2:0]       pres_fn,
  input  logic             pres_val,
  input  logic [31:0]      slot_rdata,
  output logic             fwd_rd,
  output logic             fwd_wr,
  output logic             rd_valid,
  output logic [31:0]      rd_data
);
  localparam int NFUNC = NUM_BUSES * 256;
  localparam logic [REG_W:0]   DEPTH_L = (REG_W+1)'(ROOT_DEPTH);
  localparam logic [REG_W-1:0] HDR_IDX = REG_W'(3);
  localparam logic [REG_W-1:0] WLO_IDX = REG_W'(24);
  localparam logic [REG_W-1:0] WHI_IDX = REG_W'(25);

  logic [NFUNC-1:0] pres_q;
  logic [31:0]      rf_q [ROOT_DEPTH];

  logic [BUS_W+7:0] req_idx, row_base, pres_idx;
  logic [7:0]       row;
  logic             is_root, pres_hit, sib_hit, fits, in_range;
  logic [3:0]       len_mask, byte_mask;
  logic [RI_W-1:0]  ri;
  logic             wr_root, rd_req;
  logic [31:0]      root_rd, slot_rd, rd_next;

  assign req_idx  = {req_bus, req_dev, req_fn};
  assign row_base = {req_bus, req_dev, 3'b000};
  assign pres_idx = {pres_bus, pres_dev, pres_fn};
  assign row      = pres_q[row_base +: 8];
  assign pres_hit = pres_q[req_idx];
  assign sib_hit  = |row[7:1];
  assign is_root  = (req_bus == '0) && (req_dev == '0) && (req_fn == '0);
  assign fits     = ({2'b00, req_offset} + {1'b0, req_len}) <= 4'd4;
  assign in_range = {1'b0, req_reg} < DEPTH_L;
  assign ri       = req_reg[RI_W-1:0];
  assign rd_req   = req_valid && !req_write;

  always_comb begin
    case (req_len)
      3'd1:    len_mask = 4'b0001;
      3'd2:    len_mask = 4'b0011;
      3'd3:    len_mask = 4'b0111;
      3'd4:    len_mask = 4'b1111;
      default: len_mask = 4'b0000;
    endcase
  end
  assign byte_mask = fits ? (len_mask << req_offset) : 4'b0000;

  assign wr_root = req_valid && req_write && is_root && fits && in_range && (ri != '0);
  assign fwd_wr  = req_valid && req_write && !is_root && pres_hit && fits;
  assign fwd_rd  = rd_req && !is_root && pres_hit;

  always_comb begin
    if (ecam_en && req_reg == WLO_IDX)      root_rd = ecam_base[31:0] | 32'h1;
    else if (ecam_en && req_reg == WHI_IDX) root_rd = ecam_base[63:32];
    else if (in_range)                      root_rd = rf_q[ri];
    else                                    root_rd = '0;
  end

  always_comb begin
    slot_rd = pres_hit ? slot_rdata : 32'hFFFF_FFFF;
    if (req_reg == HDR_IDX && sib_hit) slot_rd[23] = 1'b1;
  end

  assign rd_next = is_root ? root_rd : slot_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres_q <= '0;
    end else if (pres_we) begin
      pres_q[pres_idx] <= pres_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ROOT_DEPTH; i++) rf_q[i] <= '0;
      rf_q[0] <= ROOT_ID;
      rf_q[2] <= ROOT_CLASS;
    end else if (wr_root) begin
      for (int b = 0; b < 4; b++)
        if (byte_mask[b]) rf_q[ri][8*b +: 8] <= req_wdata[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/cfg_router_chk.sv
module cfg_router_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [REG_W-1:0] req_reg,
  input logic [1:0]       req_offset,
  input logic [2:0]       req_len,
  input logic             ecam_en,
  input logic             is_root,
  input logic             pres_hit,
  input logic             fwd_rd,
  input logic             fwd_wr,
  input logic             rd_valid,
  input logic [31:0]      rd_data
);
  logic oversize;
  assign oversize = ({2'b00, req_offset} + {1'b0, req_len}) > 4'd4;

  a_r1_root_stays_local: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_root) |-> (!fwd_rd && !fwd_wr));

  a_r2_window_low_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && is_root && ecam_en && req_reg == REG_W'(24)) |=> rd_data[0]);

  a_r4_absent_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !is_root && !pres_hit) |=> (rd_data == 32'hFFFF_FFFF));

  a_r4_absent_no_fwd_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (!pres_hit) |-> !fwd_rd);

  a_r6_oversize_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && oversize) |-> !fwd_wr);

  a_r7_absent_no_fwd_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (!pres_hit) |-> !fwd_wr);

  a_r9_rd_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);

  a_r9_no_spurious_rd: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid);
endmodule

bind cfg_router cfg_router_chk #(.REG_W(REG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_reg(req_reg), .req_offset(req_offset), .req_len(req_len),
  .ecam_en(ecam_en), .is_root(is_root), .pres_hit(pres_hit),
  .fwd_rd(fwd_rd), .fwd_wr(fwd_wr), .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/cfg_router_tb.sv
module cfg_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_fn = '0;
  logic [7:0]  req_reg = '0;
  logic [1:0]  req_offset = '0;
  logic [2:0]  req_len = 3'd4;
  logic [31:0] req_wdata = '0;
  logic        ecam_en = 1'b0;
  logic [63:0] ecam_base = '0;
  logic        pres_we = 1'b0, pres_val = 1'b0;
  logic [1:0]  pres_bus = '0;
  logic [4:0]  pres_dev = '0;
  logic [2:0]  pres_fn = '0;
  logic [31:0] slot_rdata = 32'h1100_0022;
  logic        fwd_rd, fwd_wr, rd_valid;
  logic [31:0] rd_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfg_router dut_i (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_pres(logic [1:0] b, logic [4:0] d, logic [2:0] f, logic v);
    @(negedge clk);
    pres_we = 1; pres_bus = b; pres_dev = d; pres_fn = f; pres_val = v;
    @(negedge clk);
    pres_we = 0;
  endtask

  // read: checks fwd_rd in request cycle, returns data after the edge
  task automatic rd(string tag, logic [1:0] b, logic [4:0] d, logic [2:0] f, logic [7:0] r,
                    logic exp_fwd, logic [31:0] exp);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_bus = b; req_dev = d; req_fn = f; req_reg = r;
    #1 check({tag, " fwd_rd"}, {31'b0, fwd_rd}, {31'b0, exp_fwd});
    @(posedge clk); #1;
    req_valid = 0;
    check({tag, " rd_valid"}, {31'b0, rd_valid}, 32'd1);
    check({tag, " rd_data"}, rd_data, exp);
  endtask

  task automatic wr(string tag, logic [1:0] b, logic [4:0] d, logic [2:0] f, logic [7:0] r,
                    logic [1:0] off, logic [2:0] len, logic [31:0] data, logic exp_fwd);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_bus = b; req_dev = d; req_fn = f; req_reg = r;
    req_offset = off; req_len = len; req_wdata = data;
    #1 check({tag, " fwd_wr"}, {31'b0, fwd_wr}, {31'b0, exp_fwd});
    @(posedge clk); #1;
    req_valid = 0; req_offset = 0; req_len = 3'd4;
    check({tag, " rd_valid after write"}, {31'b0, rd_valid}, 32'd0);
  endtask

  task automatic t_reset;
    check("R9 rd_valid in reset", {31'b0, rd_valid}, 32'd0);
    rd("R8 root id", 0, 0, 0, 0, 0, 32'h4C21_1D0B);
    rd("R8 root class", 0, 0, 0, 2, 0, 32'h0600_0000);
    rd("R8 root reg5 reset", 0, 0, 0, 5, 0, 32'h0);
  endtask

  task automatic t_root_file;
    wr("R8 full write", 0, 0, 0, 5, 0, 4, 32'hDEAD_BEEF, 0);
    rd("R8 full readback", 0, 0, 0, 5, 0, 32'hDEAD_BEEF);
    wr("R8 byte write", 0, 0, 0, 5, 2, 1, 32'h0055_0000, 0);
    rd("R8 byte readback", 0, 0, 0, 5, 0, 32'hDE55_BEEF);
    wr("R8 half write", 0, 0, 0, 5, 1, 2, 32'h0012_3400, 0);
    rd("R8 half readback", 0, 0, 0, 5, 0, 32'hDE12_34EF);
    wr("R6 oversize root", 0, 0, 0, 5, 2, 4, 32'hFFFF_FFFF, 0);
    rd("R6 root unchanged", 0, 0, 0, 5, 0, 32'hDE12_34EF);
    wr("R8 id write", 0, 0, 0, 0, 0, 4, 32'h0, 0);
    rd("R8 id read-only", 0, 0, 0, 0, 0, 32'h4C21_1D0B);
    wr("R8 out of range write", 0, 0, 0, 40, 0, 4, 32'h1234_5678, 0);
    rd("R8 out of range read", 0, 0, 0, 40, 0, 32'h0);
  endtask

  task automatic t_window;
    wr("R3 store reg24", 0, 0, 0, 24, 0, 4, 32'h1234_5678, 0);
    rd("R3 reg24 disabled", 0, 0, 0, 24, 0, 32'h1234_5678);
    rd("R3 reg25 disabled", 0, 0, 0, 25, 0, 32'h0);
    ecam_en = 1; ecam_base = 64'h0000_00AB_E000_0000;
    rd("R2 reg24 window", 0, 0, 0, 24, 0, 32'hE000_0001);
    rd("R3 reg25 window", 0, 0, 0, 25, 0, 32'h0000_00AB);
    ecam_en = 0;
    rd("R3 reg24 after disable", 0, 0, 0, 24, 0, 32'h1234_5678);
  endtask

  task automatic t_forward;
    slot_rdata = 32'hA5A5_0F0F;
    rd("R4 absent read", 1, 3, 0, 2, 0, 32'hFFFF_FFFF);
    wr("R7 absent write", 1, 3, 0, 4, 0, 4, 32'h1, 0);
    set_pres(1, 3, 0, 1);
    rd("R1 present read", 1, 3, 0, 2, 1, 32'hA5A5_0F0F);
    wr("R7 present write", 1, 3, 0, 4, 0, 4, 32'h1, 1);
    wr("R6 oversize slot", 1, 3, 0, 4, 3, 2, 32'h1, 0);
    rd("R1 root never forwards", 0, 0, 0, 2, 0, 32'h0600_0000);
  endtask

  task automatic t_multifn;
    slot_rdata = 32'h0000_0000;
    rd("R5 header single fn", 1, 3, 0, 3, 1, 32'h0);
    set_pres(1, 3, 5, 1);
    rd("R5 header with sibling", 1, 3, 0, 3, 1, 32'h0080_0000);
    rd("R5 non-header no bit", 1, 3, 0, 2, 1, 32'h0);
    set_pres(2, 7, 0, 1);
    set_pres(2, 8, 1, 1);
    rd("R5 other device sibling", 2, 7, 0, 3, 1, 32'h0);
    set_pres(0, 0, 3, 1);
    rd("R5 root header no bit", 0, 0, 0, 3, 0, 32'h0);
    set_pres(1, 3, 5, 0);
    rd("R10 cleared sibling", 1, 3, 0, 3, 1, 32'h0);
    set_pres(1, 3, 0, 0);
    rd("R10 cleared function", 1, 3, 0, 2, 0, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 check("R9 rd_valid held in reset", {31'b0, rd_valid}, 32'd0);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_root_file();
    t_window();
    t_forward();
    t_multifn();
    repeat (2) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule